// File: doc/BRIEF.md
# DMA Channel Request Capture and Reload Controller

This block is the control front end of a small multi-channel DMA engine. For every channel it keeps the enable bit and a request-pending flag. It watches for transfer requests, which come from software or from a selected peripheral interrupt line, and tells the transfer datapath when to begin. Enabling a channel primes its forward address pointer and its transfer counter from the channel's address and count-reload inputs. Each completion pulse from the datapath counts the transfer counter down by one.

A request is captured into the pending flag whether or not the channel is enabled. Software can only clear that flag. While the channel is enabled, a pending request produces a one-cycle start strobe, and the flag drops in that same cycle. Every write of 1 to the enable bit reloads the pointer and the counter, including a write to a channel that is already enabled. The address registers, the bus transfer, address stepping and arbitration between channels belong to neighbouring blocks.

Top module: `dma_req_reload`

## Requirements
- R1: The control word is laid out as bit 0 enable, bit 1 pending, bit 2 source-forward and bit 3 destination-forward. `ch_en` shows the enable bit of the last control write, one cycle after the write.
- R2: A control write with bit 0 set loads `fwd_ptr` with `src_addr` when bit 2 is set, with `dst_addr` when only bit 3 is set, and leaves the pointer unchanged when neither is set. The new value is visible on the next cycle.
- R3: A control write with bit 0 set loads `xfer_cnt` with `cnt_reload`. Otherwise each `xfer_done` pulse lowers the counter by one, wrapping below zero. A reload in the same cycle as a done pulse takes precedence.
- R4: Writing bit 0 = 1 to a channel that is already enabled repeats the pointer and counter reload.
- R5: A request sets `ch_pend` on the next cycle, whether or not the channel is enabled.
- R6: A control write with bit 1 = 0 clears the pending flag. A write with bit 1 = 1 leaves it unchanged. A request in the same cycle as a clearing write leaves the flag at 1.
- R7: `xfer_start` is high exactly while `ch_en` and `ch_pend` are both 1. That cycle clears the pending flag unless a new request arrives in it, so an isolated request gives a one-cycle strobe.
- R8: The select word is laid out as bits 3:0 line index, bit 4 group and bit 5 software trigger. A select write with bit 5 set is a software request. The trigger bit is not stored.
- R9: A peripheral request is the rising edge of `periph_irq[group*16 + index]`, using the stored select. A line held high does not request again.
- R10: Re-selecting onto a line that is already high may set the pending flag. A later clearing control write returns the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | NCH | Per-channel control-word write strobe |
| ctl_wdata | input | NCH x 4 | Control word per channel |
| sel_we | input | NCH | Per-channel select-word write strobe |
| sel_wdata | input | NCH x (log2(NSRC)+2) | Select word per channel |
| src_addr | input | NCH x AW | Source address per channel |
| dst_addr | input | NCH x AW | Destination address per channel |
| cnt_reload | input | NCH x CW | Transfer-count reload value per channel |
| periph_irq | input | 2*NSRC | Peripheral interrupt-request flags, two groups |
| xfer_done | input | NCH | Transfer completion pulse from the datapath |
| ch_en | output | NCH | Channel enable bits |
| ch_pend | output | NCH | Request-pending flags |
| fwd_ptr | output | NCH x AW | Forward address pointer per channel |
| xfer_cnt | output | NCH x CW | Transfer counter per channel |
| xfer_start | output | NCH | One-cycle transfer-start strobe |

## Verification
Enable, pending flag, pointer and counter are registered, so each shows the effect of a write, request or done pulse one clock edge after the cycle in which the stimulus was held. The start strobe is decoded from enable and pending, so it rises in that same post-edge cycle and falls one edge later. The bench changes inputs just after the rising edge and advances its reference model on the same edge from the values held before it. It compares every output at the falling edge, which lines each expected value up with the cycle in which it falls due.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;
   localparam int CTL_W    = 4;
   localparam int CTL_EN   = 0;
   localparam int CTL_PEND = 1;
   localparam int CTL_SFWD = 2;
   localparam int CTL_DFWD = 3;

   typedef struct packed {
      logic dfwd;
      logic sfwd;
      logic pend;
      logic en;
   } ctl_word_t;
endpackage

// File: rtl/dmarr_reqsel.sv
module dmarr_reqsel #(
   parameter int NSRC = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_we,
   input  logic [$clog2(NSRC)+1:0]    sel_wdata,
   input  logic [2*NSRC-1:0]          periph_irq,
   output logic                       req
);
   localparam int SELW = $clog2(NSRC);

   logic [SELW-1:0] line_idx;
   logic            line_grp;
   logic            line_prev;
   logic            line_now;
   logic            sw_req;

   assign line_now = periph_irq[{line_grp, line_idx}];
   assign sw_req   = sel_we & sel_wdata[SELW+1];
   assign req      = sw_req | (line_now & ~line_prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_idx  <= '0;
         line_grp  <= 1'b0;
         line_prev <= 1'b0;
      end else begin
         line_prev <= line_now;
         if (sel_we) begin
            line_idx <= sel_wdata[SELW-1:0];
            line_grp <= sel_wdata[SELW];
         end
      end
   end
endmodule

// File: rtl/dmarr_chan.sv
module dmarr_chan
   import dmarr_pkg::*;
#(
   parameter int AW = 20,
   parameter int CW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic [AW-1:0]    src_addr,
   input  logic [AW-1:0]    dst_addr,
   input  logic [CW-1:0]    cnt_reload,
   input  logic             xfer_done,
   input  logic             req,
   output logic             en,
   output logic             pend,
   output logic [AW-1:0]    ptr,
   output logic [CW-1:0]    cnt,
   output logic             start
);
   ctl_word_t w;
   logic      reload;
   logic      sw_clear;
   logic      pend_nxt;

   assign w        = ctl_word_t'(ctl_wdata);
   assign reload   = ctl_we & w.en;
   assign sw_clear = ctl_we & ~w.pend;
   assign start    = en & pend;

   always_comb begin
      pend_nxt = pend;
      if (start || sw_clear) pend_nxt = 1'b0;
      if (req)               pend_nxt = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         pend <= 1'b0;
         ptr  <= '0;
         cnt  <= '0;
      end else begin
         pend <= pend_nxt;
         if (ctl_we) en <= w.en;
         if (reload) begin
            if (w.sfwd)      ptr <= src_addr;
            else if (w.dfwd) ptr <= dst_addr;
            cnt <= cnt_reload;
         end else if (xfer_done) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_req_reload.sv
module dma_req_reload
   import dmarr_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int AW   = 20,
   parameter int CW   = 16,
   parameter int NSRC = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NCH-1:0]                    ctl_we,
   input  logic [NCH-1:0][CTL_W-1:0]         ctl_wdata,
   input  logic [NCH-1:0]                    sel_we,
   input  logic [NCH-1:0][$clog2(NSRC)+1:0]  sel_wdata,
   input  logic [NCH-1:0][AW-1:0]            src_addr,
   input  logic [NCH-1:0][AW-1:0]            dst_addr,
   input  logic [NCH-1:0][CW-1:0]            cnt_reload,
   input  logic [2*NSRC-1:0]                 periph_irq,
   input  logic [NCH-1:0]                    xfer_done,
   output logic [NCH-1:0]                    ch_en,
   output logic [NCH-1:0]                    ch_pend,
   output logic [NCH-1:0][AW-1:0]            fwd_ptr,
   output logic [NCH-1:0][CW-1:0]            xfer_cnt,
   output logic [NCH-1:0]                    xfer_start
);
   if (NCH < 1)                  begin : g_bad_nch  $error("NCH must be at least 1");        end
   if (AW < 1 || CW < 1)         begin : g_bad_w    $error("AW and CW must be positive");    end
   if (NSRC < 2 || (NSRC & (NSRC - 1)) != 0)
                                 begin : g_bad_nsrc $error("NSRC must be a power of two");   end

   logic [NCH-1:0] req_vec;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dmarr_reqsel #(.NSRC(NSRC)) u_sel (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel_we     (sel_we[c]),
         .sel_wdata  (sel_wdata[c]),
         .periph_irq (periph_irq),
         .req        (req_vec[c])
      );

      dmarr_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctl_we     (ctl_we[c]),
         .ctl_wdata  (ctl_wdata[c]),
         .src_addr   (src_addr[c]),
         .dst_addr   (dst_addr[c]),
         .cnt_reload (cnt_reload[c]),
         .xfer_done  (xfer_done[c]),
         .req        (req_vec[c]),
         .en         (ch_en[c]),
         .pend       (ch_pend[c]),
         .ptr        (fwd_ptr[c]),
         .cnt        (xfer_cnt[c]),
         .start      (xfer_start[c])
      );
   end
endmodule

// File: rtl/dmarr_chk.sv
module dmarr_chk #(
   parameter int NCH  = 2,
   parameter int AW   = 20,
   parameter int CW   = 16,
   parameter int NSRC = 16
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NCH-1:0]                    ctl_we,
   input logic [NCH-1:0][3:0]               ctl_wdata,
   input logic [NCH-1:0]                    sel_we,
   input logic [NCH-1:0][$clog2(NSRC)+1:0]  sel_wdata,
   input logic [NCH-1:0][AW-1:0]            src_addr,
   input logic [NCH-1:0][CW-1:0]            cnt_reload,
   input logic [NCH-1:0]                    req_vec,
   input logic [NCH-1:0]                    ch_en,
   input logic [NCH-1:0]                    ch_pend,
   input logic [NCH-1:0][AW-1:0]            fwd_ptr,
   input logic [NCH-1:0][CW-1:0]            xfer_cnt,
   input logic [NCH-1:0]                    xfer_start
);
   localparam int TRIG = $clog2(NSRC) + 1;

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_we[c] |=> ch_en[c] == $past(ctl_wdata[c][0])); // R1
      AST_SRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_we[c] && ctl_wdata[c][0] && ctl_wdata[c][2] |=> fwd_ptr[c] == $past(src_addr[c])); // R2
      AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_we[c] && ctl_wdata[c][0] |=> xfer_cnt[c] == $past(cnt_reload[c])); // R3
      AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         req_vec[c] |=> ch_pend[c]); // R5
      AST_SET_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_we[c] && ctl_wdata[c][1] && !ch_pend[c] && !req_vec[c] |=> !ch_pend[c]); // R6
      AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_start[c] && !req_vec[c] |=> !ch_pend[c] && !xfer_start[c]); // R7
      AST_SW_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
         sel_we[c] && sel_wdata[c][TRIG] |=> ch_pend[c]); // R8
   end
endmodule

bind dma_req_reload dmarr_chk #(.NCH(NCH), .AW(AW), .CW(CW), .NSRC(NSRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .ctl_wdata  (ctl_wdata),
   .sel_we     (sel_we),
   .sel_wdata  (sel_wdata),
   .src_addr   (src_addr),
   .cnt_reload (cnt_reload),
   .req_vec    (req_vec),
   .ch_en      (ch_en),
   .ch_pend    (ch_pend),
   .fwd_ptr    (fwd_ptr),
   .xfer_cnt   (xfer_cnt),
   .xfer_start (xfer_start)
);

// File: tb/sim_dma_req_reload.sv
module sim_dma_req_reload;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2, AW = 20, CW = 16, NSRC = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]           ctl_we = '0;
   logic [NCH-1:0][3:0]      ctl_wdata = '0;
   logic [NCH-1:0]           sel_we = '0;
   logic [NCH-1:0][5:0]      sel_wdata = '0;
   logic [NCH-1:0][AW-1:0]   src_addr = '0;
   logic [NCH-1:0][AW-1:0]   dst_addr = '0;
   logic [NCH-1:0][CW-1:0]   cnt_reload = '0;
   logic [2*NSRC-1:0]        periph_irq = '0;
   logic [NCH-1:0]           xfer_done = '0;
   logic [NCH-1:0]           ch_en, ch_pend, xfer_start;
   logic [NCH-1:0][AW-1:0]   fwd_ptr;
   logic [NCH-1:0][CW-1:0]   xfer_cnt;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done_run = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_req_reload #(.NCH(NCH), .AW(AW), .CW(CW), .NSRC(NSRC)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .sel_we(sel_we), .sel_wdata(sel_wdata), .src_addr(src_addr),
      .dst_addr(dst_addr), .cnt_reload(cnt_reload), .periph_irq(periph_irq),
      .xfer_done(xfer_done), .ch_en(ch_en), .ch_pend(ch_pend),
      .fwd_ptr(fwd_ptr), .xfer_cnt(xfer_cnt), .xfer_start(xfer_start));

   // reference model state
   bit          m_en   [NCH];
   bit          m_pend [NCH];
   bit          m_prev [NCH];
   int          m_idx  [NCH];
   int          m_grp  [NCH];
   logic [AW-1:0] m_ptr [NCH];
   logic [CW-1:0] m_cnt [NCH];

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            m_en[c] = 0; m_pend[c] = 0; m_prev[c] = 0;
            m_idx[c] = 0; m_grp[c] = 0; m_ptr[c] = '0; m_cnt[c] = '0;
         end else begin
            bit strobe, line, rq;
            strobe = m_en[c] && m_pend[c];
            line = periph_irq[m_grp[c]*NSRC + m_idx[c]];
            rq = (sel_we[c] && sel_wdata[c][5]) || (line && !m_prev[c]);
            m_prev[c] = line;
            if (sel_we[c]) begin
               m_idx[c] = int'(sel_wdata[c][3:0]);
               m_grp[c] = int'(sel_wdata[c][4]);
            end
            if (rq) m_pend[c] = 1;
            else if (strobe) m_pend[c] = 0;
            else if (ctl_we[c] && !ctl_wdata[c][1]) m_pend[c] = 0;
            if (ctl_we[c]) m_en[c] = ctl_wdata[c][0];
            if (ctl_we[c] && ctl_wdata[c][0]) begin
               if (ctl_wdata[c][2]) m_ptr[c] = src_addr[c];
               else if (ctl_wdata[c][3]) m_ptr[c] = dst_addr[c];
               m_cnt[c] = cnt_reload[c];
            end else if (xfer_done[c]) begin
               m_cnt[c] = m_cnt[c] - 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done_run) begin
         for (int c = 0; c < NCH; c++) begin
            chk(ch_en[c] == m_en[c], "R1 enable", ch_en[c], m_en[c]);
            chk(fwd_ptr[c] == m_ptr[c], "R2 R4 pointer", fwd_ptr[c], m_ptr[c]);
            chk(xfer_cnt[c] == m_cnt[c], "R3 R4 counter", xfer_cnt[c], m_cnt[c]);
            chk(ch_pend[c] == m_pend[c], "R5 R6 R8 R9 R10 pending", ch_pend[c], m_pend[c]);
            chk(xfer_start[c] == (m_en[c] && m_pend[c]), "R7 start",
                xfer_start[c], m_en[c] && m_pend[c]);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done_run) begin
         done_run = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr_ctl(input int c, input logic [3:0] d);
      ctl_we[c] = 1'b1; ctl_wdata[c] = d; step(); ctl_we[c] = 1'b0;
   endtask

   task automatic wr_sel(input int c, input logic [5:0] d);
      sel_we[c] = 1'b1; sel_wdata[c] = d; step(); sel_we[c] = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      src_addr[0] = 20'h1_2345; dst_addr[0] = 20'hA_BCDE; cnt_reload[0] = 16'd5;
      src_addr[1] = 20'h0_0F00; dst_addr[1] = 20'h7_7000; cnt_reload[1] = 16'd2;
      // R2 R3: enable with source-forward
      wr_ctl(0, 4'b0101);
      step();
      // R3: decrements, and reload beats done in the same cycle
      xfer_done[0] = 1'b1; repeat (3) step(); xfer_done[0] = 1'b0;
      xfer_done[0] = 1'b1; ctl_we[0] = 1'b1; ctl_wdata[0] = 4'b0101; step();
      ctl_we[0] = 1'b0; xfer_done[0] = 1'b0;
      // R4: re-enable while enabled reloads new values
      src_addr[0] = 20'h5_5555; cnt_reload[0] = 16'd9;
      wr_ctl(0, 4'b0101); step();
      // R2: flags without enable do nothing; destination-only enable
      wr_ctl(1, 4'b1000);
      wr_ctl(1, 4'b1001);
      // R3: wrap below zero
      cnt_reload[1] = 16'd0; wr_ctl(1, 4'b0001);
      xfer_done[1] = 1'b1; step(); xfer_done[1] = 1'b0; step();
      chk(xfer_cnt[1] == 16'hFFFF, "R3 wrap", xfer_cnt[1], 16'hFFFF);
      // R5 R8: software request on a disabled channel
      wr_ctl(1, 4'b0000);
      wr_sel(1, 6'b100000); step();
      chk(ch_pend[1] == 1'b1, "R5 R8 latched while disabled", ch_pend[1], 1);
      // R6: writing 1 to pending is ignored, 0 clears, request wins over clear
      wr_ctl(1, 4'b0010);
      chk(ch_pend[1] == 1'b1, "R6 write-one ignored", ch_pend[1], 1);
      wr_ctl(1, 4'b0000);
      chk(ch_pend[1] == 1'b0, "R6 write-zero clears", ch_pend[1], 0);
      ctl_we[1] = 1'b1; ctl_wdata[1] = 4'b0000; sel_we[1] = 1'b1; sel_wdata[1] = 6'b100000;
      step(); ctl_we[1] = 1'b0; sel_we[1] = 1'b0;
      chk(ch_pend[1] == 1'b1, "R6 request wins", ch_pend[1], 1);
      // R7: enabling with a pending request gives one start strobe
      wr_ctl(1, 4'b0011);
      chk(xfer_start[1] == 1'b1, "R7 strobe high", xfer_start[1], 1);
      step();
      chk(xfer_start[1] == 1'b0, "R7 strobe one cycle", xfer_start[1], 0);
      // R9: peripheral rising edge, group 0 line 3 and group 1 line 3
      wr_sel(0, 6'b000011); step();
      periph_irq[3] = 1'b1; repeat (4) step();
      periph_irq[3] = 1'b0; step();
      periph_irq[3] = 1'b1; step(); step();
      wr_sel(0, 6'b010011);
      periph_irq[NSRC+3] = 1'b1; repeat (3) step();
      // R10: re-select onto a high line, then clear
      wr_ctl(1, 4'b0000);
      periph_irq[7] = 1'b1; step();
      wr_sel(1, 6'b000111); step();
      chk(ch_pend[1] == 1'b1, "R10 select change sets", ch_pend[1], 1);
      wr_ctl(1, 4'b0000);
      chk(ch_pend[1] == 1'b0, "R10 cleared after change", ch_pend[1], 0);
      // mixed random traffic against the model
      for (int k = 0; k < 600; k++) begin
         for (int c = 0; c < NCH; c++) begin
            ctl_we[c] = ($urandom_range(0, 7) == 0);
            ctl_wdata[c] = 4'($urandom);
            sel_we[c] = ($urandom_range(0, 9) == 0);
            sel_wdata[c] = 6'($urandom);
            xfer_done[c] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) src_addr[c] = AW'($urandom);
            if ($urandom_range(0, 15) == 0) dst_addr[c] = AW'($urandom);
            if ($urandom_range(0, 15) == 0) cnt_reload[c] = CW'($urandom);
         end
         if ($urandom_range(0, 2) == 0) periph_irq[$urandom_range(0, 2*NSRC-1)] ^= 1'b1;
         step();
      end
      ctl_we = '0; sel_we = '0; xfer_done = '0;
      repeat (3) step();
      @(posedge clk);
      done_run = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule